// File: doc/BRIEF.md
# Frame-Synchronized Video Control Registers

This block is the software-facing configuration word set of a pixel-processing core. A simple 32-bit register bus (address, write strobe, write data, read strobe, read data) writes a set of visible configuration registers. The pixel datapath never sees those visible values directly. It is driven from a second, shadow copy. The shadow copy is refreshed only at a frame boundary, which is the rising edge of the vertical-blank input, and only when software has armed the refresh. A picture therefore never changes mode or size part-way through a frame.

Two software resets sit in the control word. The first takes hold at once and stays in force until software clears it. The second waits for the next frame boundary, restores every default there and then drops itself. A write to the table-swap location requests a change of the active gamma table bank. The change is performed at the next frame boundary, as a one-cycle pulse plus a toggle of the bank-select output. The table memory and the pixel path lie outside this block. The status, error, debug, timing-status and table-data locations read back zero here.

Top module: `vid_cfg_regs`

## Requirements
- R1: After the synchronous active-low reset: core_en, bypass_en, tpg_sel, swap_pulse and bank_sel are 0. act_vsize and act_hsize hold the default size. The control word reads 0x0000_0000.
- R2: Control word layout (offset 0x000): bit 0 is core enable, bit 1 is update enable, bit 4 is bypass, bit 5 is test-pattern select, bit 30 is the frame-synchronized reset request and bit 31 is the immediate reset. Written fields read back unchanged, and core_en follows bit 0 from the cycle after the write.
- R3: A vertical-blank rising edge is vblank_in sampled 1 at a clock edge after being sampled 0 at the previous one. By the second clock edge after vblank_in is first sampled high, bypass_en, tpg_sel, act_vsize and act_hsize equal the visible values, provided core enable and update enable were both set.
- R4: While update enable is clear, writes are stored and read back, but the shadow outputs do not change across a vertical-blank edge.
- R5: While core enable is clear, neither a shadow load nor a bank swap takes place at a vertical-blank edge.
- R6: While bit 31 is set: all configuration fields and the size are held at defaults, the outputs are held at their reset values, and writes to other registers and other control fields are ignored. Writing 0 to the control word releases the reset at once.
- R7: Setting bit 30 changes nothing until the next vertical-blank edge. At that edge, visible registers and outputs return to defaults and bit 30 reads 0 again.
- R8: Any write to offset 0x100 requests a bank swap. At the next vertical-blank edge with core enable set, swap_pulse is high for exactly one cycle and bank_sel toggles. With no request pending, no pulse occurs.
- R9: The size register at offset 0x020 holds the vertical size in bits 31:16 and the horizontal size in bits 15:0, and it drives act_vsize and act_hsize through the shadow copy.
- R10: The version word at offset 0x010 reads the VERSION parameter and ignores writes. Unmapped offsets read 0 and ignore writes. bus_rdata carries the value one cycle after bus_rd and is 0 otherwise.
- R11: The interrupt-enable word at offset 0x00C stores all 32 bits. Offsets 0x004, 0x008, 0x014 to 0x01C, 0x024 and 0x104 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register and frame clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| vblank_in | input | 1 | Vertical blank, synchronous to clk |
| core_en | output | 1 | Core enable, direct from the control word |
| bypass_en | output | 1 | Shadowed bypass select |
| tpg_sel | output | 1 | Shadowed test-pattern input select |
| act_vsize | output | 16 | Shadowed active vertical size |
| act_hsize | output | 16 | Shadowed active horizontal size |
| swap_pulse | output | 1 | One-cycle pulse when the table bank changes |
| bank_sel | output | 1 | Currently active gamma table bank |

## Verification
The bench targets writes made while the update arm is clear or the core is disabled. A design that ignored either gate would change bypass or size at the next vertical blank. It covers a swap request raised while the core is disabled and then served once the core is enabled. A design that lost or repeated the request would show the wrong pulse count or bank. Both resets are exercised with live state present. A faulty immediate reset would let size writes through or leave outputs set. A faulty frame reset would either act at once or leave bit 30 stuck after the edge. Random frames then mix all the control bits against a bench model of the visible and shadow state.

// File: rtl/vcr_pkg.sv
// Shared constants and types for the frame-synchronized control registers.
// Assumes a 32-bit data bus with byte offsets of ADDR_W bits.
package vcr_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_IRQ  = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_VER  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_SIZE = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_TBL  = 12'h100;

    localparam int B_EN   = 0;
    localparam int B_UPD  = 1;
    localparam int B_BYP  = 4;
    localparam int B_TPG  = 5;
    localparam int B_ARST = 30;
    localparam int B_SRST = 31;

    typedef struct packed {
        logic srst;
        logic arst;
        logic tpg;
        logic byp;
        logic upd;
        logic en;
    } ctrl_t;
endpackage

// File: rtl/vcr_vsync_edge.sv
// Vertical-blank rising-edge detector.
// Registers the input once, then compares it with its previous-cycle value.
// Assumes vblank_in is already synchronous to clk.
module vcr_vsync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic vblank_in,
    output logic rise
);
    logic vb_q;
    logic vb_d;

    // Sample the input and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vb_q <= 1'b0;
            vb_d <= 1'b0;
        end else begin
            vb_q <= vblank_in;
            vb_d <= vb_q;
        end
    end

    assign rise = vb_q & ~vb_d;

    // R3: an edge is a single-cycle event
    a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/vcr_regfile.sv
// Software-visible register file: control word, interrupt enable, size and version.
// Decodes writes, holds both software resets and returns registered read data.
// Assumes single-cycle write and read strobes.
module vcr_regfile
    import vcr_pkg::*;
#(
    parameter logic [REG_W-1:0] VERSION = 32'h0001_0200,
    parameter int               SIZE_W  = 16,
    parameter logic [SIZE_W-1:0] DEF_V  = 16'd1080,
    parameter logic [SIZE_W-1:0] DEF_H  = 16'd1920
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  rd,
    output logic [REG_W-1:0]      rdata,
    input  logic                  rise,
    output ctrl_t                 ctrl,
    output logic [2*SIZE_W-1:0]   size_vis,
    output logic                  tbl_req,
    output logic                  flush
);
    localparam logic [2*SIZE_W-1:0] DEF_SIZE = {DEF_V, DEF_H};

    ctrl_t              ctrl_q;
    logic [REG_W-1:0]   irq_q;
    logic [2*SIZE_W-1:0] size_q;
    logic [REG_W-1:0]   ctrl_word;
    logic [REG_W-1:0]   rd_mux;
    logic               hit;

    assign flush = ctrl_q.arst & rise & ~ctrl_q.srst;

    // Register writes, with immediate reset over frame reset over bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            irq_q  <= '0;
            size_q <= DEF_SIZE;
        end else if (ctrl_q.srst) begin
            ctrl_q <= '0;
            irq_q  <= '0;
            size_q <= DEF_SIZE;
            if (wr && addr == OFS_CTRL) begin
                ctrl_q.srst <= wdata[B_SRST];
                ctrl_q.arst <= wdata[B_ARST];
            end else begin
                ctrl_q.srst <= 1'b1;
            end
        end else if (flush) begin
            ctrl_q <= '0;
            irq_q  <= '0;
            size_q <= DEF_SIZE;
        end else if (wr) begin
            case (addr)
                OFS_CTRL: begin
                    ctrl_q.en   <= wdata[B_EN];
                    ctrl_q.upd  <= wdata[B_UPD];
                    ctrl_q.byp  <= wdata[B_BYP];
                    ctrl_q.tpg  <= wdata[B_TPG];
                    ctrl_q.arst <= wdata[B_ARST];
                    ctrl_q.srst <= wdata[B_SRST];
                end
                OFS_IRQ:  irq_q  <= wdata;
                OFS_SIZE: size_q <= wdata[2*SIZE_W-1:0];
                default: ;
            endcase
        end
    end

    assign tbl_req = wr && addr == OFS_TBL && !ctrl_q.srst && !flush;

    // Assemble the control word in its bus layout.
    always_comb begin
        ctrl_word         = '0;
        ctrl_word[B_EN]   = ctrl_q.en;
        ctrl_word[B_UPD]  = ctrl_q.upd;
        ctrl_word[B_BYP]  = ctrl_q.byp;
        ctrl_word[B_TPG]  = ctrl_q.tpg;
        ctrl_word[B_ARST] = ctrl_q.arst;
        ctrl_word[B_SRST] = ctrl_q.srst;
    end

    // Read decode; unmapped offsets fall through to zero.
    always_comb begin
        rd_mux = '0;
        hit    = 1'b1;
        case (addr)
            OFS_CTRL: rd_mux = ctrl_word;
            OFS_IRQ:  rd_mux = irq_q;
            OFS_VER:  rd_mux = VERSION;
            OFS_SIZE: rd_mux = REG_W'(size_q);
            default:  hit    = 1'b0;
        endcase
    end

    // Register the read data for one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd ? rd_mux : '0;
    end

    assign ctrl     = ctrl_q;
    assign size_vis = size_q;

    // R7: the frame reset request drops itself at the edge
    a_r7_arst_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.arst && rise && !ctrl_q.srst) |=> (!ctrl_q.arst && !ctrl_q.en && size_q == DEF_SIZE));
    // R6: a held immediate reset keeps fields at defaults
    a_r6_hold_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.srst && $past(ctrl_q.srst)) |-> (!ctrl_q.en && !ctrl_q.upd && size_q == DEF_SIZE));
    // R10: unmapped reads return zero, idle cycles return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd || !hit) |=> rdata == '0);
endmodule

// File: rtl/vcr_shadow.sv
// Shadow copy of the datapath configuration and the gamma bank-swap sequencer.
// Loads only at a vertical-blank edge with enable and update set; a clear input
// (either software reset) forces defaults and wins over a load.
module vcr_shadow #(
    parameter int                SIZE_W = 16,
    parameter logic [SIZE_W-1:0] DEF_V  = 16'd1080,
    parameter logic [SIZE_W-1:0] DEF_H  = 16'd1920
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rise,
    input  logic                en,
    input  logic                upd,
    input  logic                byp,
    input  logic                tpg,
    input  logic [2*SIZE_W-1:0] size_vis,
    input  logic                tbl_req,
    input  logic                clear,
    output logic                sh_byp,
    output logic                sh_tpg,
    output logic [SIZE_W-1:0]   sh_v,
    output logic [SIZE_W-1:0]   sh_h,
    output logic                swap_pulse,
    output logic                bank
);
    logic load;
    logic fire;
    logic pend;

    assign load = rise & en & upd;
    assign fire = rise & en & pend & ~clear;

    // Shadow configuration: clear, else frame-boundary load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh_byp <= 1'b0;
            sh_tpg <= 1'b0;
            sh_v   <= DEF_V;
            sh_h   <= DEF_H;
        end else if (load) begin
            sh_byp <= byp;
            sh_tpg <= tpg;
            sh_v   <= size_vis[2*SIZE_W-1:SIZE_W];
            sh_h   <= size_vis[SIZE_W-1:0];
        end
    end

    // Swap request latch, bank toggle and one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend       <= 1'b0;
            bank       <= 1'b0;
            swap_pulse <= 1'b0;
        end else begin
            swap_pulse <= fire;
            if (fire) bank <= ~bank;
            if (tbl_req)   pend <= 1'b1;
            else if (fire) pend <= 1'b0;
        end
    end

    // R4: without a load or clear the shadow holds
    a_r4_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clear) |=> ($stable(sh_byp) && $stable(sh_tpg) && $stable(sh_v) && $stable(sh_h)));
    // R8: each pulse accompanies a bank change and follows an edge
    a_r8_pulse_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |-> (bank != $past(bank) && $past(rise)));
    // R8: pulse lasts one cycle
    a_r8_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        swap_pulse |=> !swap_pulse);
    // R6: a clear drives outputs to reset values
    a_r6_clear_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!sh_byp && !sh_tpg && !bank && !swap_pulse && sh_v == DEF_V && sh_h == DEF_H));
endmodule

// File: rtl/vid_cfg_regs.sv
// Top of the frame-synchronized control register block.
// Wires the edge detector, visible register file and shadow copy together.
// Assumes vblank_in is synchronous to clk.
module vid_cfg_regs
    import vcr_pkg::*;
#(
    parameter logic [31:0] VERSION = 32'h0001_0200,
    parameter int          SIZE_W  = 16,
    parameter logic [SIZE_W-1:0] DEF_V = 16'd1080,
    parameter logic [SIZE_W-1:0] DEF_H = 16'd1920
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [11:0]       bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              vblank_in,
    output logic              core_en,
    output logic              bypass_en,
    output logic              tpg_sel,
    output logic [SIZE_W-1:0] act_vsize,
    output logic [SIZE_W-1:0] act_hsize,
    output logic              swap_pulse,
    output logic              bank_sel
);
    logic                rise;
    ctrl_t               ctrl;
    logic [2*SIZE_W-1:0] size_vis;
    logic                tbl_req;
    logic                flush;

    vcr_vsync_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .vblank_in (vblank_in),
        .rise      (rise)
    );

    vcr_regfile #(
        .VERSION (VERSION),
        .SIZE_W  (SIZE_W),
        .DEF_V   (DEF_V),
        .DEF_H   (DEF_H)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rd       (bus_rd),
        .rdata    (bus_rdata),
        .rise     (rise),
        .ctrl     (ctrl),
        .size_vis (size_vis),
        .tbl_req  (tbl_req),
        .flush    (flush)
    );

    vcr_shadow #(
        .SIZE_W (SIZE_W),
        .DEF_V  (DEF_V),
        .DEF_H  (DEF_H)
    ) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .en         (ctrl.en),
        .upd        (ctrl.upd),
        .byp        (ctrl.byp),
        .tpg        (ctrl.tpg),
        .size_vis   (size_vis),
        .tbl_req    (tbl_req),
        .clear      (ctrl.srst | flush),
        .sh_byp     (bypass_en),
        .sh_tpg     (tpg_sel),
        .sh_v       (act_vsize),
        .sh_h       (act_hsize),
        .swap_pulse (swap_pulse),
        .bank       (bank_sel)
    );

    assign core_en = ctrl.en & ~ctrl.srst;

    // R2: core enable never shows while the immediate reset is held
    a_r2_enable_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.srst |-> !core_en);
endmodule

// File: tb/vid_cfg_regs_tb.sv
module vid_cfg_regs_tb;
    localparam int PERIOD = 10;
    localparam logic [31:0] VER = 32'h0001_0200;
    localparam logic [15:0] DV = 16'd1080;
    localparam logic [15:0] DH = 16'd1920;
    localparam logic [31:0] DSIZE = {DV, DH};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        vblank_in = 1'b0;
    logic        core_en, bypass_en, tpg_sel, swap_pulse, bank_sel;
    logic [15:0] act_vsize, act_hsize;

    int checks = 0;
    int bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    vid_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .vblank_in(vblank_in), .core_en(core_en), .bypass_en(bypass_en),
        .tpg_sel(tpg_sel), .act_vsize(act_vsize), .act_hsize(act_hsize),
        .swap_pulse(swap_pulse), .bank_sel(bank_sel)
    );

    // Count swap pulses, sampled mid-cycle.
    always @(negedge clk) if (rst_n && swap_pulse) pulses++;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic frame();
        @(negedge clk);
        vblank_in = 1'b1;
        repeat (3) @(negedge clk);
        vblank_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pulses = 0;
    endtask

    function automatic logic [31:0] ctrl_word(input bit en, upd, byp, tpg);
        logic [31:0] w = '0;
        w[0] = en; w[1] = upd; w[4] = byp; w[5] = tpg;
        return w;
    endfunction

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int p0;
        bit m_en, m_upd, m_byp, m_tpg, m_pend, m_bank;
        bit s_byp, s_tpg;
        logic [31:0] m_size, s_size;
        int m_pulses;

        do_reset();
        // R1 reset state
        chk("R1", "core_en", 32'(core_en), 0);
        chk("R1", "bypass", 32'(bypass_en), 0);
        chk("R1", "tpg", 32'(tpg_sel), 0);
        chk("R1", "bank", 32'(bank_sel), 0);
        chk("R1", "size", {act_vsize, act_hsize}, DSIZE);
        bus_read(12'h000, r); chk("R1", "ctrl read", r, 0);

        // R10 version, unmapped, idle rdata
        bus_read(12'h010, r); chk("R10", "version", r, VER);
        bus_write(12'h010, 32'hFFFF_FFFF);
        bus_read(12'h010, r); chk("R10", "version after write", r, VER);
        bus_write(12'h040, 32'hDEAD_BEEF);
        bus_read(12'h040, r); chk("R10", "unmapped", r, 0);
        @(negedge clk); chk("R10", "idle rdata", bus_rdata, 0);

        // R11 irq enable and zero words
        bus_write(12'h00C, 32'hA5A5_0F0F);
        bus_read(12'h00C, r); chk("R11", "irq enable", r, 32'hA5A5_0F0F);
        bus_read(12'h004, r); chk("R11", "status", r, 0);
        bus_read(12'h104, r); chk("R11", "table data", r, 0);

        // R2 layout and immediate core enable
        bus_write(12'h000, 32'h33);
        chk("R2", "core_en", 32'(core_en), 1);
        bus_read(12'h000, r); chk("R2", "ctrl read", r, 32'h33);
        chk("R2", "bypass not yet", 32'(bypass_en), 0);

        // R4 update gate
        bus_write(12'h000, 32'h11);
        frame();
        chk("R4", "bypass held", 32'(bypass_en), 0);
        bus_read(12'h000, r); chk("R4", "ctrl stored", r, 32'h11);
        bus_write(12'h000, 32'h13);
        frame();
        chk("R3", "bypass loaded", 32'(bypass_en), 1);
        chk("R3", "tpg loaded", 32'(tpg_sel), 0);

        // R5 enable gate, swap request while disabled
        bus_write(12'h000, 32'h22);
        bus_write(12'h100, 32'h1);
        frame();
        chk("R5", "tpg held", 32'(tpg_sel), 0);
        chk("R5", "bypass held", 32'(bypass_en), 1);
        chk("R5", "no pulse", pulses, 0);
        chk("R5", "core_en", 32'(core_en), 0);

        // R8 pending swap served once enabled
        bus_write(12'h000, 32'h01);
        frame();
        chk("R8", "pulse count", pulses, 1);
        chk("R8", "bank", 32'(bank_sel), 1);
        frame();
        chk("R8", "no extra pulse", pulses, 1);
        chk("R8", "bypass kept", 32'(bypass_en), 1);

        // R9 size packing
        bus_write(12'h020, 32'h0123_0456);
        bus_write(12'h000, 32'h03);
        frame();
        chk("R9", "vsize", 32'(act_vsize), 32'h123);
        chk("R9", "hsize", 32'(act_hsize), 32'h456);
        bus_read(12'h020, r); chk("R9", "size read", r, 32'h0123_0456);

        // R6 immediate reset
        bus_write(12'h000, 32'h13);
        frame();
        chk("R6", "bypass before", 32'(bypass_en), 1);
        p0 = pulses;
        bus_write(12'h000, 32'h8000_0000);
        repeat (2) @(negedge clk);
        chk("R6", "core_en", 32'(core_en), 0);
        chk("R6", "bypass", 32'(bypass_en), 0);
        chk("R6", "bank", 32'(bank_sel), 0);
        chk("R6", "size", {act_vsize, act_hsize}, DSIZE);
        bus_read(12'h000, r); chk("R6", "ctrl read", r, 32'h8000_0000);
        bus_write(12'h020, 32'h0000_0055);
        bus_write(12'h100, 32'h1);
        bus_read(12'h020, r); chk("R6", "size write ignored", r, DSIZE);
        bus_write(12'h000, 32'h0);
        bus_read(12'h000, r); chk("R6", "released", r, 0);
        bus_write(12'h000, 32'h01);
        frame();
        chk("R6", "swap write ignored", pulses, p0);
        chk("R6", "bank after", 32'(bank_sel), 0);

        // R7 frame-synchronized reset
        bus_write(12'h000, 32'h13);
        frame();
        bus_write(12'h020, 32'h0007_0008);
        bus_write(12'h000, 32'h4000_0013);
        bus_read(12'h000, r); chk("R7", "pending read", r, 32'h4000_0013);
        chk("R7", "bypass before edge", 32'(bypass_en), 1);
        chk("R7", "core_en before edge", 32'(core_en), 1);
        frame();
        bus_read(12'h000, r); chk("R7", "ctrl after edge", r, 0);
        chk("R7", "bypass", 32'(bypass_en), 0);
        chk("R7", "core_en", 32'(core_en), 0);
        chk("R7", "size out", {act_vsize, act_hsize}, DSIZE);
        bus_read(12'h020, r); chk("R7", "size read", r, DSIZE);

        // Random frames against a model (R3 R4 R5 R8)
        void'($urandom(32'd4242));
        do_reset();
        m_pend = 0; m_bank = 0; s_byp = 0; s_tpg = 0; s_size = DSIZE; m_pulses = 0;
        for (int i = 0; i < 60; i++) begin
            m_en  = ($urandom_range(0, 3) != 0);
            m_upd = ($urandom_range(0, 2) != 0);
            m_byp = $urandom_range(0, 1);
            m_tpg = $urandom_range(0, 1);
            m_size = $urandom;
            bus_write(12'h000, ctrl_word(m_en, m_upd, m_byp, m_tpg));
            bus_write(12'h020, m_size);
            if ($urandom_range(0, 2) == 0) begin
                bus_write(12'h100, $urandom);
                m_pend = 1;
            end
            frame();
            if (m_en && m_upd) begin
                s_byp = m_byp; s_tpg = m_tpg; s_size = m_size;
            end
            if (m_en && m_pend) begin
                m_bank = ~m_bank; m_pend = 0; m_pulses++;
            end
            chk("R3", "rand core_en", 32'(core_en), 32'(m_en));
            chk("R4", "rand bypass", 32'(bypass_en), 32'(s_byp));
            chk("R4", "rand tpg", 32'(tpg_sel), 32'(s_tpg));
            chk("R5", "rand size", {act_vsize, act_hsize}, s_size);
            chk("R8", "rand bank", 32'(bank_sel), 32'(m_bank));
            chk("R8", "rand pulses", pulses, m_pulses);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule